// File: doc/BRIEF.md
# Bus Access Protection Checker

This block sits beside a multi-master bus fabric and checks every bus access against a table of programmable address regions. Each master has its own check port. An access presents its address, its kind (read, write, execute or a reserved code), its privilege level and a process tag. One cycle later the port reports whether the access is allowed or refused. Regions can overlap. A region can be limited to one process tag. The rights in a region are kept separately for every master. Masters marked as processors also carry execute rights and separate supervisor and user rights.

Region descriptors are loaded through a simple write-only configuration port. A descriptor is ignored by the checks until its enable bit is set, so software can rebuild it safely. The first refused access is held in a sticky error record. That record stays until software clears it by writing a 1 to the clear register. All check ports work every cycle and never stall, so the block has no ready signal and applies no back-pressure. A valid access is always consumed in the cycle it is presented.

Top module: `bmpu_top`

## Requirements
- R1: For each port, an access presented with `acc_valid` high gives `chk_valid` high in the next cycle, with exactly one of `chk_grant` and `chk_fault` high. With no access presented, `chk_valid` is low in the next cycle.
- R2: A region matches an address when address bits [31:5] lie between the region's start bits [31:5] and end bits [31:5], both bounds included. Address bits [4:0] play no part in the match.
- R3: When several regions match an access, the access is granted if any matching region gives the needed right. It is refused only when none of them does.
- R4: An access that matches no enabled region is refused. A region takes part only while its enable bit (descriptor word 3, bit 0) is 1, so a fully permissive region that is disabled grants nothing.
- R5: For a non-processor master m, the region rights word grants read with bit 6m+0 and write with bit 6m+1. The privilege level is ignored, and execute is always refused.
- R6: For a processor master m, user accesses use bits 6m+0, 6m+1 and 6m+2 (read, write, execute). Supervisor accesses (`acc_priv`=1) use bits 6m+3, 6m+4 and 6m+5. Ports 0 and 1 are processors by default.
- R7: When descriptor word 3 bit 1 is set, the region matches only if `acc_pid` equals word 3 bits [15:8].
- R8: All ports are checked in the same cycle, each independently of the others.
- R9: A refused access while the error flag is clear sets `err_flag` and records the full address, the port number and the access kind. If several ports fail in the same cycle, the lowest-numbered port is recorded. Later refusals do not overwrite the record while the flag is set.
- R10: A configuration write to address 64 with data bit 0 set clears `err_flag`. With bit 0 clear, the write has no effect. A refusal in the same cycle as a clear sets the flag again and records the new access.
- R11: After reset all regions are disabled, `err_flag` is low and no port shows `chk_valid`.
- R12: The access kind encoding is 0 read, 1 write, 2 execute, 3 reserved. A reserved kind is always refused.
- R13: Configuration address 4r+k writes word k of region r. Word 0 is the start (bits [31:5]). Word 1 is the inclusive end (bits [31:5]). Word 2 holds the rights, 6 bits per master. Word 3 holds enable, process match and process tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration word address (region words 0..63, error clear 64) |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 4 | Access present, one bit per port |
| acc_addr | input | 4x32 | Access address per port |
| acc_kind | input | 4x2 | Access kind per port (0 read, 1 write, 2 execute, 3 reserved) |
| acc_priv | input | 4 | 1 = supervisor, 0 = user, per port |
| acc_pid | input | 4x8 | Process tag per port |
| chk_valid | output | 4 | Check result present, per port |
| chk_grant | output | 4 | Access allowed, per port |
| chk_fault | output | 4 | Access refused, per port |
| err_flag | output | 1 | Sticky error flag |
| err_addr | output | 32 | Address of the recorded refusal |
| err_master | output | 2 | Port number of the recorded refusal |
| err_kind | output | 2 | Access kind of the recorded refusal |

## Verification
Every check result is due exactly one clock edge after the cycle its access is presented. A monitor samples just after each rising edge and pops one expected verdict per port that shows `chk_valid`. A port with an expectation queued but no result counts as a miss, so late and early answers both fail. The error record and flag change on the same edge as the verdict, and configuration writes take effect on the edge that accepts them. The bench therefore reads `err_*` one cycle after the refusal or clear write, before any later stimulus.

// File: rtl/bmpu_pkg.sv
package bmpu_pkg;

  localparam int GRAN_BITS = 5;   // 32-byte region granularity
  localparam int RIGHT_W   = 6;   // rights bits per master per region

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_kind_e;

  // Evaluate one master's rights field for one access.
  // bits: [0] user read [1] user write [2] user exec
  //       [3] sup read  [4] sup write  [5] sup exec
  function automatic logic right_ok(input logic [RIGHT_W-1:0] bits,
                                    input logic is_proc,
                                    input logic priv,
                                    input logic [1:0] kind);
    logic sup;
    sup = is_proc & priv;
    case (acc_kind_e'(kind))
      ACC_RD:  right_ok = sup ? bits[3] : bits[0];
      ACC_WR:  right_ok = sup ? bits[4] : bits[1];
      ACC_EX:  right_ok = is_proc & (sup ? bits[5] : bits[2]);
      default: right_ok = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/bmpu_region_file.sv
module bmpu_region_file
  import bmpu_pkg::*;
#(
  parameter int NR     = 16,
  parameter int NP     = 4,
  parameter int AW     = 32,
  parameter int PIDW   = 8,
  parameter int CFG_AW = 7
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [CFG_AW-1:0]               cfg_addr,
  input  logic [AW-1:0]                   cfg_wdata,
  output logic [NR-1:0][AW-GRAN_BITS-1:0] rg_start,
  output logic [NR-1:0][AW-GRAN_BITS-1:0] rg_end,
  output logic [NR-1:0][NP*RIGHT_W-1:0]   rg_rights,
  output logic [NR-1:0]                   rg_valid,
  output logic [NR-1:0]                   rg_pid_en,
  output logic [NR-1:0][PIDW-1:0]         rg_pid
);

  localparam int IW = CFG_AW - 2;

  logic [IW-1:0] sel;
  logic [1:0]    word;
  assign sel  = cfg_addr[CFG_AW-1:2];
  assign word = cfg_addr[1:0];

  for (genvar r = 0; r < NR; r++) begin : g_reg
    logic hit_w;
    assign hit_w = cfg_we && (sel == IW'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rg_start[r]  <= '0;
        rg_end[r]    <= '0;
        rg_rights[r] <= '0;
        rg_valid[r]  <= 1'b0;
        rg_pid_en[r] <= 1'b0;
        rg_pid[r]    <= '0;
      end else if (hit_w) begin
        case (word)
          2'd0: rg_start[r]  <= cfg_wdata[AW-1:GRAN_BITS];
          2'd1: rg_end[r]    <= cfg_wdata[AW-1:GRAN_BITS];
          2'd2: rg_rights[r] <= cfg_wdata[NP*RIGHT_W-1:0];
          default: begin
            rg_valid[r]  <= cfg_wdata[0];
            rg_pid_en[r] <= cfg_wdata[1];
            rg_pid[r]    <= cfg_wdata[8 +: PIDW];
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/bmpu_port_check.sv
module bmpu_port_check
  import bmpu_pkg::*;
#(
  parameter int   NR      = 16,
  parameter int   AW      = 32,
  parameter int   PIDW    = 8,
  parameter logic IS_PROC = 1'b1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            acc_valid,
  input  logic [AW-GRAN_BITS-1:0]         acc_page,
  input  logic [1:0]                      acc_kind,
  input  logic                            acc_priv,
  input  logic [PIDW-1:0]                 acc_pid,
  input  logic [NR-1:0][AW-GRAN_BITS-1:0] rg_start,
  input  logic [NR-1:0][AW-GRAN_BITS-1:0] rg_end,
  input  logic [NR-1:0][RIGHT_W-1:0]      rg_rights_m,
  input  logic [NR-1:0]                   rg_valid,
  input  logic [NR-1:0]                   rg_pid_en,
  input  logic [NR-1:0][PIDW-1:0]         rg_pid,
  output logic                            fault_now,
  output logic                            res_valid,
  output logic                            res_grant,
  output logic                            res_fault
);

  logic [NR-1:0] hit;
  logic [NR-1:0] ok;

  for (genvar r = 0; r < NR; r++) begin : g_cmp
    assign hit[r] = rg_valid[r]
                  && (acc_page >= rg_start[r])
                  && (acc_page <= rg_end[r])
                  && (!rg_pid_en[r] || (rg_pid[r] == acc_pid));
    assign ok[r]  = hit[r] && right_ok(rg_rights_m[r], IS_PROC, acc_priv, acc_kind);
  end

  assign fault_now = acc_valid && !(|ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_grant <= 1'b0;
      res_fault <= 1'b0;
    end else begin
      res_valid <= acc_valid;
      res_grant <= acc_valid && (|ok);
      res_fault <= fault_now;
    end
  end

  // R1: verdict one cycle later, exactly one of grant/fault
  a_r1_verdict_next: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (res_valid && (res_grant != res_fault)));

  // R1: no access, no verdict
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!res_valid && !res_grant && !res_fault));

  // R4: nothing matched means refusal
  a_r4_nohit_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !(|hit)) |=> res_fault);

endmodule

// File: rtl/bmpu_err_capture.sv
module bmpu_err_capture #(
  parameter int NP = 4,
  parameter int AW = 32,
  parameter int MW = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NP-1:0]          fault_now,
  input  logic [NP-1:0][AW-1:0]  acc_addr,
  input  logic [NP-1:0][1:0]     acc_kind,
  input  logic                   clr,
  output logic                   err_flag,
  output logic [AW-1:0]          err_addr,
  output logic [MW-1:0]          err_master,
  output logic [1:0]             err_kind
);

  logic [MW-1:0] pick;
  logic          any_fault;

  assign any_fault = |fault_now;

  // lowest-numbered failing port wins
  always_comb begin
    pick = '0;
    for (int p = NP - 1; p >= 0; p--) begin
      if (fault_now[p]) pick = MW'(p);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag   <= 1'b0;
      err_addr   <= '0;
      err_master <= '0;
      err_kind   <= '0;
    end else if (any_fault && (!err_flag || clr)) begin
      err_flag   <= 1'b1;
      err_addr   <= acc_addr[pick];
      err_master <= pick;
      err_kind   <= acc_kind[pick];
    end else if (clr) begin
      err_flag   <= 1'b0;
    end
  end

  // R9: flag rises only on a refusal
  a_r9_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(any_fault));

  // R9: record held while flag set and not cleared
  a_r9_record_held: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !clr) |=> (err_flag && $stable(err_addr) && $stable(err_master)
                            && $stable(err_kind)));

  // R10: clear without a new refusal drops the flag
  a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !any_fault) |=> !err_flag);

endmodule

// File: rtl/bmpu_top.sv
module bmpu_top
  import bmpu_pkg::*;
#(
  parameter int              NR        = 16,
  parameter int              NP        = 4,
  parameter int              AW        = 32,
  parameter int              PIDW      = 8,
  parameter logic [NP-1:0]   PROC_MASK = NP'(3),
  localparam int             CFG_AW    = $clog2(NR * 4) + 1,
  localparam int             MW        = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [CFG_AW-1:0]         cfg_addr,
  input  logic [AW-1:0]             cfg_wdata,
  input  logic [NP-1:0]             acc_valid,
  input  logic [NP-1:0][AW-1:0]     acc_addr,
  input  logic [NP-1:0][1:0]        acc_kind,
  input  logic [NP-1:0]             acc_priv,
  input  logic [NP-1:0][PIDW-1:0]   acc_pid,
  output logic [NP-1:0]             chk_valid,
  output logic [NP-1:0]             chk_grant,
  output logic [NP-1:0]             chk_fault,
  output logic                      err_flag,
  output logic [AW-1:0]             err_addr,
  output logic [MW-1:0]             err_master,
  output logic [1:0]                err_kind
);

  logic [NR-1:0][AW-GRAN_BITS-1:0] rg_start;
  logic [NR-1:0][AW-GRAN_BITS-1:0] rg_end;
  logic [NR-1:0][NP*RIGHT_W-1:0]   rg_rights;
  logic [NR-1:0]                   rg_valid;
  logic [NR-1:0]                   rg_pid_en;
  logic [NR-1:0][PIDW-1:0]         rg_pid;
  logic [NP-1:0]                   fault_now;
  logic                            clr;

  assign clr = cfg_we && (cfg_addr == CFG_AW'(NR * 4)) && cfg_wdata[0];

  bmpu_region_file #(
    .NR(NR), .NP(NP), .AW(AW), .PIDW(PIDW), .CFG_AW(CFG_AW)
  ) u_regions (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rg_start(rg_start), .rg_end(rg_end), .rg_rights(rg_rights),
    .rg_valid(rg_valid), .rg_pid_en(rg_pid_en), .rg_pid(rg_pid)
  );

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic [NR-1:0][RIGHT_W-1:0] rights_m;
    for (genvar r = 0; r < NR; r++) begin : g_slice
      assign rights_m[r] = rg_rights[r][p*RIGHT_W +: RIGHT_W];
    end

    bmpu_port_check #(
      .NR(NR), .AW(AW), .PIDW(PIDW), .IS_PROC(PROC_MASK[p])
    ) u_chk (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid[p]),
      .acc_page(acc_addr[p][AW-1:GRAN_BITS]),
      .acc_kind(acc_kind[p]),
      .acc_priv(acc_priv[p]),
      .acc_pid(acc_pid[p]),
      .rg_start(rg_start), .rg_end(rg_end), .rg_rights_m(rights_m),
      .rg_valid(rg_valid), .rg_pid_en(rg_pid_en), .rg_pid(rg_pid),
      .fault_now(fault_now[p]),
      .res_valid(chk_valid[p]), .res_grant(chk_grant[p]), .res_fault(chk_fault[p])
    );
  end

  bmpu_err_capture #(.NP(NP), .AW(AW), .MW(MW)) u_err (
    .clk(clk), .rst_n(rst_n),
    .fault_now(fault_now), .acc_addr(acc_addr), .acc_kind(acc_kind), .clr(clr),
    .err_flag(err_flag), .err_addr(err_addr), .err_master(err_master),
    .err_kind(err_kind)
  );

  // R11: nothing reported straight out of reset
  a_r11_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (chk_valid == '0));

endmodule

// File: tb/bmpu_top_tb_top.sv
module bmpu_top_tb_top;

  localparam int NP = 4;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  cfg_we = 1'b0;
  logic [6:0]            cfg_addr = '0;
  logic [31:0]           cfg_wdata = '0;
  logic [NP-1:0]         acc_valid = '0;
  logic [NP-1:0][31:0]   acc_addr = '0;
  logic [NP-1:0][1:0]    acc_kind = '0;
  logic [NP-1:0]         acc_priv = '0;
  logic [NP-1:0][7:0]    acc_pid = '0;
  logic [NP-1:0]         chk_valid, chk_grant, chk_fault;
  logic                  err_flag;
  logic [31:0]           err_addr;
  logic [1:0]            err_master, err_kind;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  mon_on   = 1'b0;
  bit  exp_q[NP][$];
  string tag_q[NP][$];

  always #4 clk = ~clk;   // 125 MHz

  bmpu_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_kind(acc_kind),
    .acc_priv(acc_priv), .acc_pid(acc_pid),
    .chk_valid(chk_valid), .chk_grant(chk_grant), .chk_fault(chk_fault),
    .err_flag(err_flag), .err_addr(err_addr), .err_master(err_master),
    .err_kind(err_kind)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: present an access on a port and queue its expected verdict
  task automatic put(input int p, input logic [31:0] a, input logic [1:0] k,
                     input logic pv, input logic [7:0] pid, input bit grant,
                     input string req);
    acc_valid[p] = 1'b1;
    acc_addr[p]  = a;
    acc_kind[p]  = k;
    acc_priv[p]  = pv;
    acc_pid[p]   = pid;
    exp_q[p].push_back(grant);
    tag_q[p].push_back(req);
  endtask

  task automatic tick();
    @(negedge clk);
    acc_valid = '0;
    cfg_we    = 1'b0;
  endtask

  task automatic cfg_set(input logic [6:0] a, input logic [31:0] d);
    cfg_we    = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    cfg_set(a, d);
    tick();
  endtask

  task automatic one(input int p, input logic [31:0] a, input logic [1:0] k,
                     input logic pv, input logic [7:0] pid, input bit grant,
                     input string req);
    put(p, a, k, pv, pid, grant, req);
    tick();
  endtask

  // monitor: verdicts are due one edge after the access
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (mon_on) begin
        for (int p = 0; p < NP; p++) begin
          if (chk_valid[p]) begin
            if (exp_q[p].size() == 0) begin
              check(1'b0, "R1", $sformatf("port%0d unexpected verdict", p), 64'(chk_valid[p]), 64'd0);
            end else begin
              bit    e;
              string t;
              e = exp_q[p].pop_front();
              t = tag_q[p].pop_front();
              check((chk_grant[p] == e) && (chk_fault[p] == !e), t,
                    $sformatf("port%0d grant/fault", p),
                    64'({chk_grant[p], chk_fault[p]}), 64'({e, !e}));
            end
          end else if (exp_q[p].size() != 0) begin
            void'(exp_q[p].pop_front());
            check(1'b0, tag_q[p].pop_front(), $sformatf("port%0d verdict missing (R1)", p),
                  64'd0, 64'd1);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(chk_valid == '0, "R11", "chk_valid in reset", 64'(chk_valid), 64'd0);
    check(err_flag == 1'b0, "R11", "err_flag in reset", 64'(err_flag), 64'd0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    tick();

    // R4/R11: no region enabled yet -> refusal, first error recorded (R9)
    one(1, 32'h0000_0ABC, 2'd2, 1'b1, 8'h00, 1'b0, "R4");
    check(err_flag == 1'b1, "R9", "flag after first refusal", 64'(err_flag), 64'd1);
    check(err_addr == 32'h0ABC, "R9", "err_addr", 64'(err_addr), 64'h0ABC);
    check(err_master == 2'd1, "R9", "err_master", 64'(err_master), 64'd1);
    check(err_kind == 2'd2, "R9", "err_kind", 64'(err_kind), 64'd2);

    // R13: load descriptors; region 3 stays disabled but fully permissive
    wr(7'd12, 32'h0000_8000); wr(7'd13, 32'h0000_8FE0); wr(7'd14, 32'h00FF_FFFF); wr(7'd15, 32'h0);
    wr(7'd0,  32'h0000_1000); wr(7'd1,  32'h0000_1FE0); wr(7'd2,  32'h0004_3039); wr(7'd3,  32'h1);
    wr(7'd4,  32'h0000_1800); wr(7'd5,  32'h0000_27E0); wr(7'd6,  32'h0000_0042); wr(7'd7,  32'h1);
    wr(7'd8,  32'h0000_4000); wr(7'd9,  32'h0000_4000); wr(7'd10, 32'h0004_0001); wr(7'd11, 32'h5A03);

    // R6: processor user/supervisor rights
    one(0, 32'h1000, 2'd0, 1'b0, 8'h0, 1'b1, "R6");
    one(0, 32'h1000, 2'd1, 1'b0, 8'h0, 1'b0, "R6");
    one(0, 32'h1000, 2'd1, 1'b1, 8'h0, 1'b1, "R6");
    one(0, 32'h1000, 2'd2, 1'b0, 8'h0, 1'b0, "R6");
    one(0, 32'h1000, 2'd2, 1'b1, 8'h0, 1'b1, "R6");
    // R3: overlap, second region supplies the right
    one(0, 32'h1900, 2'd1, 1'b0, 8'h0, 1'b1, "R3");
    one(1, 32'h1000, 2'd0, 1'b0, 8'h0, 1'b0, "R3");
    one(1, 32'h1800, 2'd0, 1'b0, 8'h0, 1'b1, "R3");
    // R2: bounds inclusive at 32-byte granularity
    one(1, 32'h27FF, 2'd0, 1'b0, 8'h0, 1'b1, "R2");
    one(1, 32'h2800, 2'd0, 1'b0, 8'h0, 1'b0, "R2");
    one(0, 32'h0FFF, 2'd0, 1'b0, 8'h0, 1'b0, "R2");
    one(0, 32'h101F, 2'd0, 1'b0, 8'h0, 1'b1, "R2");
    // R5: non-processor masters
    one(2, 32'h1000, 2'd1, 1'b0, 8'h0, 1'b1, "R5");
    one(2, 32'h1000, 2'd1, 1'b1, 8'h0, 1'b1, "R5");
    one(2, 32'h1000, 2'd2, 1'b1, 8'h0, 1'b0, "R5");
    one(3, 32'h1000, 2'd1, 1'b0, 8'h0, 1'b0, "R5");
    one(3, 32'h1000, 2'd0, 1'b0, 8'h0, 1'b1, "R5");
    // R7: process tag match
    one(3, 32'h4010, 2'd0, 1'b0, 8'h5A, 1'b1, "R7");
    one(3, 32'h4010, 2'd0, 1'b0, 8'h5B, 1'b0, "R7");
    one(0, 32'h4010, 2'd0, 1'b0, 8'h5A, 1'b1, "R7");
    // R4: disabled region and uncovered address
    one(2, 32'h8000, 2'd0, 1'b0, 8'h0, 1'b0, "R4");
    one(2, 32'h3000, 2'd0, 1'b0, 8'h0, 1'b0, "R4");
    // R12: reserved kind
    one(0, 32'h1000, 2'd3, 1'b1, 8'h0, 1'b0, "R12");
    // R8: four ports at once
    put(0, 32'h1000, 2'd0, 1'b0, 8'h0, 1'b1, "R8");
    put(1, 32'h1000, 2'd0, 1'b0, 8'h0, 1'b0, "R8");
    put(2, 32'h1004, 2'd1, 1'b0, 8'h0, 1'b1, "R8");
    put(3, 32'h1008, 2'd1, 1'b0, 8'h0, 1'b0, "R8");
    tick();

    // R9: record still the first refusal
    check(err_addr == 32'h0ABC, "R9", "record sticky addr", 64'(err_addr), 64'h0ABC);
    check(err_master == 2'd1, "R9", "record sticky master", 64'(err_master), 64'd1);
    // R10: clear write with bit0=0 has no effect, with bit0=1 clears
    wr(7'd64, 32'h0);
    check(err_flag == 1'b1, "R10", "flag after no-op clear", 64'(err_flag), 64'd1);
    wr(7'd64, 32'h1);
    check(err_flag == 1'b0, "R10", "flag after clear", 64'(err_flag), 64'd0);
    // R9: simultaneous refusals, lowest port recorded
    put(3, 32'h3000, 2'd0, 1'b0, 8'h0, 1'b0, "R9");
    put(1, 32'h3100, 2'd1, 1'b0, 8'h0, 1'b0, "R9");
    tick();
    check(err_flag == 1'b1, "R9", "flag set", 64'(err_flag), 64'd1);
    check(err_master == 2'd1, "R9", "lowest port", 64'(err_master), 64'd1);
    check(err_addr == 32'h3100, "R9", "addr of lowest port", 64'(err_addr), 64'h3100);
    check(err_kind == 2'd1, "R9", "kind of lowest port", 64'(err_kind), 64'd1);
    // R10: clear and refusal in the same cycle
    cfg_set(7'd64, 32'h1);
    put(2, 32'h8000, 2'd0, 1'b0, 8'h0, 1'b0, "R10");
    tick();
    check(err_flag == 1'b1, "R10", "flag re-set", 64'(err_flag), 64'd1);
    check(err_addr == 32'h8000, "R10", "new addr", 64'(err_addr), 64'h8000);
    check(err_master == 2'd2, "R10", "new master", 64'(err_master), 64'd2);

    tick();
    tick();
    for (int p = 0; p < NP; p++) begin
      check(exp_q[p].size() == 0, "R1", $sformatf("port%0d queue drained", p),
            64'(exp_q[p].size()), 64'd0);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

endmodule